// File: doc/BRIEF.md
# Multi-Stage Protected Watchdog Timer

This block is a watchdog that runs on a slow clock. It counts through four cascaded timeout stages. Each stage has its own tick budget and its own action on expiry: nothing, a sticky interrupt, a CPU reset pulse, a system reset pulse, or a full reset pulse. Software reaches it over a small word-addressed register port. Writes to the configuration, the timeout registers and the feed register take effect only while a key register holds the magic key value. Status and timeouts can always be read.

Software unlocks the block and programs the four timeouts and the action codes. It sets the enable bit (or the boot-mode bit), then feeds the block periodically. If the feeds stop, the stages fire one after another, each performing its action. After the last stage the block sits idle until it is fed or restarted. A pause option freezes counting while the sleep input is high. Each reset output is a single pulse whose length is set by a 3-bit code.

Register map (3-bit word address):
- 0: key
- 1: control
- 2: feed
- 3 to 6: timeout of stages 0 to 3
- 7: status and interrupt clear

Control fields:
- bit 0: enable
- bit 1: boot-mode enable
- bit 2: pause in sleep
- bits [5:3], [8:6], [11:9], [14:12]: action codes of stages 0 to 3
- bits [17:15]: system length code
- bits [20:18]: CPU length code

Status fields:
- bit 0: running
- bit 1: interrupt
- bits [3:2]: stage pointer
- bit 4: locked

Top module: `wdt_top`

## Requirements
- R1: The block is unlocked only while the key register (address 0) holds KEY_VAL. Any other value, including the reset value 0, means locked. Reading address 0 returns the locked flag in bit 0, and status bit 4 shows the same flag.
- R2: While locked, writes to control (address 1), feed (address 2) and timeouts (addresses 3 to 6) change nothing. Reads of every register still return the stored values.
- R3: A stage with timeout value N expires on its N-th counted cycle after it was entered. A timeout of 0 behaves as 1.
- R4: When stages 0, 1 or 2 expire, the stage pointer advances and a fresh count starts. When stage 3 expires, counting stops with the pointer at 3 until a feed or a disable.
- R5: Action codes are 1 = interrupt, 2 = CPU reset, 3 = system reset, 4 = full reset. Codes 0 and 5 to 7 produce no output.
- R6: A write of 1 in bit 0 of the feed register restarts counting at stage 0 with a zero count.
- R7: While the pause bit (control bit 2) is set and sleepIn is high, the count and the stage pointer hold.
- R8: The running flag (status bit 0) is the OR of the enable and boot-mode bits. While both are clear, the count and the stage pointer stay at zero.
- R9: A reset pulse lasts 2^(code+1) cycles. The CPU output uses the code in control bits [20:18]; the system and full outputs use the code in control bits [17:15]. A new trigger reloads the length.
- R10: irqOut stays high until a write to address 7 with bit 1 set clears it. The clear works whether the block is locked or not. A new interrupt expiry in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr (combinational) |
| sleepIn | input | 1 | Sleep indication |
| irqOut | output | 1 | Sticky interrupt |
| cpuRstOut | output | 1 | CPU reset pulse |
| sysRstOut | output | 1 | System reset pulse |
| fullRstOut | output | 1 | Full reset pulse |

## Verification
Most wrong internal states reach the ports only late. A stage pointer or count that is off by one shows up as an action pulse one cycle early or late, or on the wrong output, but only when that stage expires. The bench closes the gap by reading the status register every idle cycle, so the stage pointer, the running flag and the lock flag are compared on the cycle after they change. A lock leak appears at the first readback of control or a timeout. A wrong pulse length appears on the cycle the pulse should have ended.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int STAGES = 4;
  localparam int STG_W  = $clog2(STAGES);
  localparam int ACT_W  = 3;
  localparam int LEN_W  = 3;
  localparam int ADDR_W = 3;

  // control register layout
  localparam int BIT_EN      = 0;
  localparam int BIT_BOOT    = 1;
  localparam int BIT_PAUSE   = 2;
  localparam int ACT_LSB     = 3;
  localparam int SYS_LEN_LSB = ACT_LSB + STAGES * ACT_W;
  localparam int CPU_LEN_LSB = SYS_LEN_LSB + LEN_W;
  localparam int CTRL_W      = CPU_LEN_LSB + LEN_W;

  localparam logic [ADDR_W-1:0] ADDR_KEY    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FEED   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TMO0   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd7;

  typedef enum logic [ACT_W-1:0] {
    ACT_OFF  = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CPU  = 3'd2,
    ACT_SYS  = 3'd3,
    ACT_FULL = 3'd4
  } act_e;

  localparam int RST_KINDS = 3;
  localparam int RK_CPU    = 0;
  localparam int RK_SYS    = 1;
  localparam int RK_FULL   = 2;

  typedef struct packed {
    logic              wrCtrl;
    logic [STAGES-1:0] wrTmo;
    logic              feed;
    logic              irqClr;
  } wdtStb_t;
endpackage

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int CODE_W = LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trig,
  input  logic [CODE_W-1:0] code,
  output logic              pulseOut
);
  localparam int CNT_W = (1 << CODE_W) + 1;

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (trig) begin
      remain <= CNT_W'(1) << ({1'b0, code} + (CODE_W + 1)'(1));
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign pulseOut = |remain;
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output wdtStb_t           stb,
  output logic              locked
);
  logic [DATA_W-1:0] keyReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg <= '0;
    end else if (wrEn && addr == ADDR_KEY) begin
      keyReg <= wdata;
    end
  end

  assign locked = (keyReg != KEY_VAL);

  always_comb begin
    stb.wrCtrl = wrEn && !locked && (addr == ADDR_CTRL);
    stb.feed   = wrEn && !locked && (addr == ADDR_FEED) && wdata[0];
    stb.irqClr = wrEn && (addr == ADDR_STATUS) && wdata[1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : gTmoStb
    assign stb.wrTmo[s] = wrEn && !locked && (addr == ADDR_TMO0 + ADDR_W'(s));
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] DEF_TMO = 32'd2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStb_t           stb,
  input  logic              locked,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sleepIn,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              cpuRstOut,
  output logic              sysRstOut,
  output logic              fullRstOut,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              running,
  output logic [STG_W-1:0]  stagePtr,
  output logic [DATA_W-1:0] cntVal
);
  logic [DATA_W-1:0]    tmoReg [STAGES];
  logic                 done;
  logic                 irqReg;
  logic                 paused;
  logic                 hit;
  logic                 expire;
  logic [DATA_W-1:0]    curTmo;
  logic [ACT_W-1:0]     curAct;
  logic [LEN_W-1:0]     cpuLen;
  logic [LEN_W-1:0]     sysLen;
  logic [RST_KINDS-1:0] trigVec;
  logic [RST_KINDS-1:0] pulseVec;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (stb.wrCtrl) begin
      ctrlReg <= wdata[CTRL_W-1:0];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : gTmo
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tmoReg[s] <= DEF_TMO;
      end else if (stb.wrTmo[s]) begin
        tmoReg[s] <= wdata;
      end
    end
  end

  assign running = ctrlReg[BIT_EN] | ctrlReg[BIT_BOOT];
  assign paused  = ctrlReg[BIT_PAUSE] & sleepIn;
  assign cpuLen  = ctrlReg[CPU_LEN_LSB +: LEN_W];
  assign sysLen  = ctrlReg[SYS_LEN_LSB +: LEN_W];

  always_comb begin
    curTmo = tmoReg[0];
    curAct = ctrlReg[ACT_LSB +: ACT_W];
    for (int i = 0; i < STAGES; i++) begin
      if (stagePtr == STG_W'(i)) begin
        curTmo = tmoReg[i];
        curAct = ctrlReg[ACT_LSB + ACT_W * i +: ACT_W];
      end
    end
  end

  assign hit    = ({1'b0, cntVal} + (DATA_W + 1)'(1)) >= {1'b0, curTmo};
  assign expire = running && !stb.feed && !done && !paused && hit;

  // stage sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= '0;
      stagePtr <= '0;
      done     <= 1'b0;
    end else if (!running || stb.feed) begin
      cntVal   <= '0;
      stagePtr <= '0;
      done     <= 1'b0;
    end else if (!done && !paused) begin
      if (hit) begin
        cntVal <= '0;
        if (stagePtr == STG_W'(STAGES - 1)) begin
          done <= 1'b1;
        end else begin
          stagePtr <= stagePtr + STG_W'(1);
        end
      end else begin
        cntVal <= cntVal + DATA_W'(1);
      end
    end
  end

  // sticky interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReg <= 1'b0;
    end else if (expire && curAct == ACT_IRQ) begin
      irqReg <= 1'b1;
    end else if (stb.irqClr) begin
      irqReg <= 1'b0;
    end
  end
  assign irqOut = irqReg;

  // reset pulse generators
  for (genvar k = 0; k < RST_KINDS; k++) begin : gPulse
    localparam act_e KACT = (k == RK_CPU) ? ACT_CPU : (k == RK_SYS) ? ACT_SYS : ACT_FULL;
    assign trigVec[k] = expire && (curAct == KACT);
    wdt_pulse #(.CODE_W(LEN_W)) uPulse (
      .clk     (clk),
      .rstN    (rstN),
      .trig    (trigVec[k]),
      .code    ((k == RK_CPU) ? cpuLen : sysLen),
      .pulseOut(pulseVec[k])
    );
  end

  assign cpuRstOut  = pulseVec[RK_CPU];
  assign sysRstOut  = pulseVec[RK_SYS];
  assign fullRstOut = pulseVec[RK_FULL];

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_KEY:    rdata[0] = locked;
      ADDR_CTRL:   rdata[CTRL_W-1:0] = ctrlReg;
      ADDR_STATUS: rdata[STG_W+2:0] = {locked, stagePtr, irqReg, running};
      default:     rdata = '0;
    endcase
    for (int i = 0; i < STAGES; i++) begin
      if (addr == ADDR_TMO0 + ADDR_W'(i)) rdata = tmoReg[i];
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = 32'hA5C3_9E17,
  parameter logic [DATA_W-1:0] DEF_TMO = 32'd2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sleepIn,
  output logic              irqOut,
  output logic              cpuRstOut,
  output logic              sysRstOut,
  output logic              fullRstOut
);
  wdtStb_t           stb;
  logic              locked;
  logic [CTRL_W-1:0] ctrlReg;
  logic              running;
  logic [STG_W-1:0]  stagePtr;
  logic [DATA_W-1:0] cntVal;

  wdt_ctrl #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .wdata (wdata),
    .stb   (stb),
    .locked(locked)
  );

  wdt_datapath #(.DATA_W(DATA_W), .DEF_TMO(DEF_TMO)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .locked    (locked),
    .addr      (addr),
    .wdata     (wdata),
    .sleepIn   (sleepIn),
    .rdata     (rdata),
    .irqOut    (irqOut),
    .cpuRstOut (cpuRstOut),
    .sysRstOut (sysRstOut),
    .fullRstOut(fullRstOut),
    .ctrlReg   (ctrlReg),
    .running   (running),
    .stagePtr  (stagePtr),
    .cntVal    (cntVal)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              sleepIn,
  input logic              irqOut,
  input logic              locked,
  input logic [CTRL_W-1:0] ctrlReg,
  input logic              running,
  input logic [STG_W-1:0]  stagePtr,
  input logic [DATA_W-1:0] cntVal,
  input logic              feed
);
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_KEY && wdata == KEY_VAL |=> !locked); // R1

  AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    locked && wrEn && addr == ADDR_CTRL |=> $stable(ctrlReg)); // R2

  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    running && ctrlReg[BIT_PAUSE] && sleepIn && !feed |=> $stable(cntVal) && $stable(stagePtr)); // R7

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> stagePtr == '0 && cntVal == '0); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !(wrEn && addr == ADDR_STATUS && wdata[1]) |=> irqOut); // R10
endmodule

bind wdt_top wdt_chk #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wdata   (wdata),
  .sleepIn (sleepIn),
  .irqOut  (irqOut),
  .locked  (locked),
  .ctrlReg (ctrlReg),
  .running (running),
  .stagePtr(stagePtr),
  .cntVal  (cntVal),
  .feed    (stb.feed)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam logic [31:0] KEY = 32'hA5C3_9E17;
  localparam logic [31:0] DEF = 32'd2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addrIn = 3'd7;
  logic [31:0] wdataIn = '0;
  logic        sleepIn = 1'b0;
  logic [31:0] rdata;
  logic        irqOut, cpuRstOut, sysRstOut, fullRstOut;

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R1";

  // clock period 8 time units (125 MHz)
  always #4 clk = ~clk;

  wdt_top #(.DATA_W(32), .KEY_VAL(KEY), .DEF_TMO(DEF)) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addrIn),
    .wdata     (wdataIn),
    .rdata     (rdata),
    .sleepIn   (sleepIn),
    .irqOut    (irqOut),
    .cpuRstOut (cpuRstOut),
    .sysRstOut (sysRstOut),
    .fullRstOut(fullRstOut)
  );

  // behavioural reference model
  logic [31:0] mKey;
  logic [20:0] mCtrl;
  longint      mTmo[4];
  longint      mCnt;
  int          mStage;
  bit          mDone, mIrq;
  int          mRem[3];

  initial begin
    mKey = 0; mCtrl = 0; mCnt = 0; mStage = 0; mDone = 0; mIrq = 0;
    for (int i = 0; i < 4; i++) mTmo[i] = DEF;
    for (int k = 0; k < 3; k++) mRem[k] = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mKey = 0; mCtrl = 0; mCnt = 0; mStage = 0; mDone = 0; mIrq = 0;
      for (int i = 0; i < 4; i++) mTmo[i] = DEF;
      for (int k = 0; k < 3; k++) mRem[k] = 0;
    end else begin
      bit lk, run, fd, pz, ex, irqSet;
      int act;
      lk  = (mKey != KEY);
      run = mCtrl[0] | mCtrl[1];
      fd  = wrEn && addrIn == 3'd2 && wdataIn[0] && !lk;
      pz  = mCtrl[2] && sleepIn;
      ex  = 0; act = 0; irqSet = 0;
      for (int k = 0; k < 3; k++) if (mRem[k] > 0) mRem[k]--;
      if (!run || fd) begin
        mCnt = 0; mStage = 0; mDone = 0;
      end else if (!mDone && !pz) begin
        if (mCnt + 1 >= mTmo[mStage]) begin
          ex = 1; act = int'(mCtrl[3 + 3 * mStage +: 3]);
          mCnt = 0;
          if (mStage == 3) mDone = 1; else mStage++;
        end else mCnt++;
      end
      if (ex) begin
        case (act)
          1: irqSet = 1;
          2: mRem[0] = 1 << (int'(mCtrl[20:18]) + 1);
          3: mRem[1] = 1 << (int'(mCtrl[17:15]) + 1);
          4: mRem[2] = 1 << (int'(mCtrl[17:15]) + 1);
          default: ;
        endcase
      end
      if (irqSet) mIrq = 1;
      else if (wrEn && addrIn == 3'd7 && wdataIn[1]) mIrq = 0;
      if (wrEn && addrIn == 3'd0) mKey = wdataIn;
      if (wrEn && !lk) begin
        if (addrIn == 3'd1) mCtrl = wdataIn[20:0];
        if (addrIn >= 3'd3 && addrIn <= 3'd6) mTmo[addrIn - 3] = wdataIn;
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    logic [31:0] r;
    bit lk;
    lk = (mKey != KEY);
    r = '0;
    case (a)
      3'd0: r[0] = lk;
      3'd1: r[20:0] = mCtrl;
      3'd7: begin
        r[0] = mCtrl[0] | mCtrl[1];
        r[1] = mIrq;
        r[3:2] = mStage[1:0];
        r[4] = lk;
      end
      3'd3, 3'd4, 3'd5, 3'd6: r = mTmo[a - 3][31:0];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic cmp1(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmp1("rdata", rdata, modelRead(addrIn));
    cmp1("irqOut", {31'b0, irqOut}, {31'b0, mIrq});
    cmp1("cpuRstOut", {31'b0, cpuRstOut}, {31'b0, mRem[0] != 0});
    cmp1("sysRstOut", {31'b0, sysRstOut}, {31'b0, mRem[1] != 0});
    cmp1("fullRstOut", {31'b0, fullRstOut}, {31'b0, mRem[2] != 0});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addrIn = a; wdataIn = d;
    tick();
    wrEn = 1'b0; addrIn = 3'd7; wdataIn = '0;
  endtask

  task automatic rd(input logic [2:0] a);
    addrIn = a;
    tick();
    addrIn = 3'd7;
  endtask

  function automatic logic [31:0] mk(input bit en, input bit boot, input bit pause,
                                     input int a0, input int a1, input int a2, input int a3,
                                     input int sysL, input int cpuL);
    logic [31:0] v;
    v = '0;
    v[0] = en; v[1] = boot; v[2] = pause;
    v[5:3] = 3'(a0); v[8:6] = 3'(a1); v[11:9] = 3'(a2); v[14:12] = 3'(a3);
    v[17:15] = 3'(sysL); v[20:18] = 3'(cpuL);
    return v;
  endfunction

  initial begin
    #(8 * 100000);
    mismatched++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1: reset state is locked
    curReq = "R1";
    idle(2); rd(3'd0);
    // R2: locked writes ignored, registers still readable
    curReq = "R2";
    wr(3'd1, mk(1, 0, 0, 1, 1, 1, 1, 0, 0));
    wr(3'd3, 32'd5); wr(3'd2, 32'd1);
    rd(3'd1); rd(3'd3); idle(3);
    // R1: key unlocks, wrong key relocks
    curReq = "R1";
    wr(3'd0, KEY); rd(3'd0);
    wr(3'd0, KEY ^ 32'd1); rd(3'd0); idle(1);
    wr(3'd0, KEY); rd(3'd0);
    // R3 R4 R5 R9: full cascade with all four actions
    curReq = "R4";
    wr(3'd3, 32'd5); wr(3'd4, 32'd3); wr(3'd5, 32'd4); wr(3'd6, 32'd2);
    rd(3'd5);
    wr(3'd1, mk(1, 0, 0, 1, 2, 3, 4, 2, 0));
    idle(40);
    // R10: interrupt clear works while locked
    curReq = "R10";
    wr(3'd0, 32'd0); idle(2);
    wr(3'd7, 32'd2); idle(3);
    // R6: feed ignored while locked, then restarts from stage 0
    curReq = "R6";
    wr(3'd2, 32'd1); idle(3);
    wr(3'd0, KEY);
    wr(3'd2, 32'd1); idle(3);
    wr(3'd2, 32'd1); idle(20);
    // R7: pause in sleep
    curReq = "R7";
    wr(3'd1, mk(1, 0, 1, 1, 0, 0, 0, 0, 0)); wr(3'd7, 32'd2);
    wr(3'd2, 32'd1); idle(2);
    sleepIn = 1'b1; idle(10);
    sleepIn = 1'b0; idle(10);
    wr(3'd1, mk(1, 0, 0, 1, 0, 0, 0, 0, 0)); wr(3'd2, 32'd1);
    sleepIn = 1'b1; idle(8);
    sleepIn = 1'b0;
    // R8: boot-mode bit alone runs, clearing both stops
    curReq = "R8";
    wr(3'd7, 32'd2);
    wr(3'd1, mk(0, 1, 0, 0, 2, 0, 0, 0, 1)); wr(3'd2, 32'd1);
    idle(7);
    wr(3'd1, mk(0, 0, 0, 0, 2, 0, 0, 0, 1)); idle(4);
    // R5: codes 0 and 5..7 do nothing
    curReq = "R5";
    wr(3'd1, mk(1, 0, 0, 5, 6, 7, 0, 0, 0)); wr(3'd2, 32'd1);
    idle(25);
    // R3: zero timeout acts as one
    curReq = "R3";
    wr(3'd3, 32'd0);
    wr(3'd1, mk(1, 0, 0, 1, 0, 0, 0, 0, 0)); wr(3'd2, 32'd1);
    idle(5); wr(3'd7, 32'd2); idle(2);
    // R9: longest pulse codes
    curReq = "R9";
    wr(3'd3, 32'd1); wr(3'd4, 32'd1); wr(3'd5, 32'd1); wr(3'd6, 32'd1);
    wr(3'd1, mk(1, 0, 0, 2, 3, 4, 0, 5, 7)); wr(3'd2, 32'd1);
    idle(300);
    // R9: retrigger reloads
    wr(3'd1, mk(1, 0, 0, 2, 2, 0, 0, 0, 1)); wr(3'd2, 32'd1);
    idle(12);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule